// File: doc/BRIEF.md
# Timestamped Probe Event FIFO

This block is a small trace buffer on a memory-mapped slave port. Instrumented code marks a checkpoint by issuing one write into the probe address window. The block then pushes a 32-bit record into an internal FIFO. Each record pairs a three-bit probe number, taken from the low bits of the write address, with the low 29 bits of a shared free-running timer. The written data is never looked at. A probe therefore costs one posted write and no read on the hot path.

Later, a handler drains the records in the order they arrived by reading a pop address. It can also read a status word that reports the fill level and the empty, full and sticky overflow flags. The timer itself is outside the block and arrives on an input.

Address decode uses the most significant address bit. When that bit is 1, the access falls in the probe window. When it is 0, the access is a register access, and address bit 0 picks between pop (0) and status (1).

Top module: `probe_trace_fifo`

## Requirements
- R1: After reset the FIFO is empty, the status word reads 0x100 (count 0, empty set, full and overflow clear) and rdata is 0.
- R2: An access with sel=1, wr=1, rd=0 and addr[4]=1 pushes exactly one record when the FIFO is not full, whatever the value on wdata. Writes with addr[4]=0, and any access with sel=0, push nothing.
- R3: A pushed record holds addr[2:0] in bits 31:29 and tstamp[28:0] in bits 28:0. The timer value used is the one present in the cycle the write is accepted.
- R4: A pop read (sel=1, rd=1, wr=0, addr[4]=0, addr[0]=0) on a non-empty FIFO returns the oldest record and removes it, so records leave in arrival order.
- R5: A pop read on an empty FIFO returns 0 and leaves the count at 0.
- R6: A probe write while the FIFO holds 8 records is discarded, leaves the stored records unchanged and sets the sticky overflow flag.
- R7: A status read (sel=1, rd=1, wr=0, addr[4]=0, addr[0]=1) returns the count in bits 3:0, empty in bit 8, full in bit 9 and overflow in bit 10, all other bits 0. The same read clears the overflow flag.
- R8: Read data appears on rdata at the clock edge that accepts the read and holds until the next read. A read in the probe window returns 0.
- R9: An access with both rd=1 and wr=1 has no effect on the FIFO contents or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Slave select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 5 | Word address; bit 4 selects the probe window, bits 2:0 the probe number |
| wdata | input | 32 | Write data, ignored |
| tstamp | input | 32 | Shared free-running timer |
| rdata | output | 32 | Registered read data |

## Verification
A probe write changes the count at the edge that accepts it. A pop or status read loads rdata at that same edge. The bench therefore drives each access on a falling edge and samples one falling edge later, when every result of that access has settled and no later access has yet started. The expected record for every probe is formed from the address and timer value driven for the accepting edge and queued in the scoreboard. Status reads are compared as whole words, so count, empty, full and the overflow clear-on-read are checked in the cycle after each read.

// File: rtl/probe_trace_fifo.sv
module probe_trace_fifo #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  parameter int ID_W   = 3,
  parameter int TS_W   = 29,
  parameter int TMR_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ID_W+TS_W-1:0] wdata,
  input  logic [TMR_W-1:0]     tstamp,
  output logic [ID_W+TS_W-1:0] rdata
);
  localparam int REC_W = ID_W + TS_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             ovf;

  wire acc_wr   = sel & wr & ~rd;
  wire acc_rd   = sel & rd & ~wr;
  wire in_win   = addr[ADDR_W-1];
  wire empty    = (count == '0);
  wire full     = (count == CNT_W'(DEPTH));
  wire push_req = acc_wr & in_win;
  wire push     = push_req & ~full;
  wire drop     = push_req & full;
  wire pop_sel  = acc_rd & ~in_win & ~addr[0];
  wire stat_sel = acc_rd & ~in_win & addr[0];
  wire pop      = pop_sel & ~empty;

  logic unused_bits;
  assign unused_bits = ^{wdata, tstamp, addr};

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [REC_W-1:0] status;
  always_comb begin
    status = '0;
    status[CNT_W-1:0] = count;
    status[8]  = empty;
    status[9]  = full;
    status[10] = ovf;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {addr[ID_W-1:0], tstamp[TS_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      rdata <= '0;
    end else begin
      if (push) begin
        wptr  <= nxt(wptr);
        count <= count + CNT_W'(1);
      end
      if (pop) begin
        rptr  <= nxt(rptr);
        count <= count - CNT_W'(1);
      end
      if (drop) ovf <= 1'b1;
      else if (stat_sel) ovf <= 1'b0;
      if (acc_rd) begin
        if (pop) rdata <= mem[rptr];
        else if (stat_sel) rdata <= status;
        else rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/probe_trace_fifo_chk.sv
module probe_trace_fifo_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  parameter int REC_W  = 32,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [REC_W-1:0]  rdata,
  input logic [CNT_W-1:0]  count,
  input logic              ovf
);
  wire w_probe = sel && wr && !rd && addr[ADDR_W-1];
  wire r_pop   = sel && rd && !wr && !addr[ADDR_W-1] && !addr[0];
  wire r_stat  = sel && rd && !wr && !addr[ADDR_W-1] && addr[0];

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (w_probe && count < CNT_W'(DEPTH)) |=> count == $past(count) + CNT_W'(1));

  a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (r_pop && count != '0) |=> count == $past(count) - CNT_W'(1));

  a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (r_pop && count == '0) |=> (rdata == '0 && count == '0));

  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (w_probe && count == CNT_W'(DEPTH)) |=> (ovf && count == CNT_W'(DEPTH)));

  a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    r_stat |=> !ovf);

  a_r9_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd && wr) |=> ($stable(count) && $stable(rdata)));
endmodule

bind probe_trace_fifo probe_trace_fifo_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .REC_W(REC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
  .rdata(rdata), .count(count), .ovf(ovf)
);

// File: tb/probe_trace_fifo_tb.sv
module probe_trace_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, tstamp = '0;
  logic [31:0] rdata;
  logic [31:0] ts = 32'hE000_0011;
  logic [31:0] sb [$];
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  probe_trace_fifo u_dut (.clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .tstamp(tstamp), .rdata(rdata));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic s, input logic r, input logic w,
                       input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = s; rd = r; wr = w; addr = a; wdata = d;
    tstamp = ts; ts = ts + 32'h0123_4567;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic probe(input logic [2:0] id, input logic [31:0] d, input bit expect_kept);
    logic [31:0] rec;
    rec = {id, ts[28:0]};
    cycle(1'b1, 1'b0, 1'b1, {2'b10, id}, d);
    if (expect_kept) sb.push_back(rec);
  endtask

  task automatic pop_check(input string req);
    logic [31:0] exp;
    exp = (sb.size() > 0) ? sb.pop_front() : 32'h0;
    cycle(1'b1, 1'b1, 1'b0, 5'b00000, 32'h0);
    check(req, rdata, exp);
  endtask

  task automatic status_check(input string req, input logic [31:0] exp);
    cycle(1'b1, 1'b1, 1'b0, 5'b00001, 32'h0);
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata after reset", rdata, 32'h0);
    status_check("R1 status after reset", 32'h100);

    probe(3'd5, 32'hDEAD_BEEF, 1);
    probe(3'd0, 32'h0000_0000, 1);
    probe(3'd7, 32'hFFFF_FFFF, 1);
    status_check("R2 count after three probes", 32'h003);
    pop_check("R3 R4 first record");
    pop_check("R3 R4 second record");
    pop_check("R4 third record");
    status_check("R4 empty after drain", 32'h100);

    pop_check("R5 empty pop returns zero");
    status_check("R5 count stays zero", 32'h100);

    cycle(1'b1, 1'b0, 1'b1, 5'b00011, 32'h1234_5678);
    cycle(1'b0, 1'b0, 1'b1, 5'b10010, 32'h1234_5678);
    status_check("R2 non-window and unselected writes push nothing", 32'h100);
    cycle(1'b1, 1'b1, 1'b1, 5'b10001, 32'h0);
    status_check("R9 rd and wr together ignored", 32'h100);

    for (int i = 0; i < 8; i++) probe(3'(i ^ 3), 32'h5A5A_0000 + 32'(i), 1);
    status_check("R7 full status", 32'h208);
    probe(3'd6, 32'h0BAD_0BAD, 0);
    status_check("R6 R7 overflow flagged", 32'h608);
    status_check("R7 overflow cleared by read", 32'h208);
    cycle(1'b1, 1'b1, 1'b0, 5'b10100, 32'h0);
    check("R8 probe window read returns zero", rdata, 32'h0);
    for (int i = 0; i < 8; i++) pop_check("R6 R4 records after overflow");
    status_check("R6 drained", 32'h100);

    status_check("R8 status read", 32'h100);
    @(negedge clk);
    check("R8 rdata held between reads", rdata, 32'h100);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule